// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical page number by walking a two-level tree of page tables kept in memory. A requester, usually the miss path of a TLB, hands over one virtual address. The walker reads a first-level entry, then a second-level entry, and returns either a translation with read and write permission bits or a page fault that names the level where the walk stopped. Software takes no part in a successful walk.

The top ten address bits index the first-level table and the next ten bits index a second-level table. The low twelve bits pass through as the offset inside a 4 KB page. Each table holds 1024 entries of four bytes. The first-level table is found through a root register. On a context switch, software rewrites this register and nothing else. Memory is reached through a read port that has a valid/ready request and a one-cycle data return, with at most one read in flight.

Every entry uses the same layout:
- bit 0 marks the entry valid;
- bit 1 grants read permission;
- bit 2 grants write permission;
- bits 31:12 hold the base of the next table or of the page frame;
- bits 11:3 are ignored.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, `resp_valid` is 0 and `mem_rd_valid` is 0. The root register resets to zero.
- R2: The first memory read of a walk uses the address root + 4 × vaddr[31:22].
- R3: The second read uses the address {first_entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R4: If both entries have bit 0 set, the response carries `resp_fault`=0, `resp_ppn`=second_entry[31:12], `resp_paddr`={second_entry[31:12], vaddr[11:0]}, `resp_perm_r`=second_entry[1] and `resp_perm_w`=second_entry[2]. Bits 11:3 of either entry have no effect.
- R5: If the first entry has bit 0 clear, the walk makes exactly one read. The response carries `resp_fault`=1 and `resp_fault_lvl`=0, with ppn, paddr and both permission bits set to zero.
- R6: If the first entry is valid but the second has bit 0 clear, the response carries `resp_fault`=1 and `resp_fault_lvl`=1, with ppn, paddr and both permission bits set to zero.
- R7: `req_ready` goes low in the cycle after a request is accepted. It stays low through the response cycle and returns high in the cycle after. Any `req_valid` raised during that window is ignored.
- R8: `resp_valid` is high for exactly one cycle per accepted request.
- R9: A write to the root register takes effect for requests accepted after it. A write made during a walk does not change the walk already in progress.
- R10: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready`. A new read is never issued while a previous one is still outstanding. A valid translation makes exactly two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_wr_en | input | 1 | Write strobe for the root register |
| root_wr_data | input | 32 | New byte address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Walk ended on an invalid entry |
| resp_fault_lvl | output | 1 | Level that faulted: 0 first, 1 second |
| resp_ppn | output | 20 | Physical page number |
| resp_paddr | output | 32 | Physical address: page number and offset |
| resp_perm_r | output | 1 | Read permission of the page |
| resp_perm_w | output | 1 | Write permission of the page |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rdata_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry word |

## Verification
The bench builds the walker with its default split of 10 + 10 index bits and a 12-bit offset. It models memory as a hash of the address, so every table exists without storage. With that model it sweeps all 1024 first-level indices under one root. It then sweeps all 1024 second-level indices under a first-level entry that is known to be valid. Between them, these sweeps cover valid pages, faults at both levels, every permission combination and many offsets. A second pass applies memory back-pressure. Dedicated walks cover a root rewrite in the middle of a walk and requests raised while the walker is busy.

// File: rtl/pt_walk_pkg.sv
// Package: shared constants, entry layout and walk states for the page table walker.
// Assumes 32-bit entries and 4 KB pages; the frame/table base sits above the offset.
package pt_walk_pkg;

    localparam int PTE_W      = 32;
    localparam int PA_W       = 32;
    localparam int PAGE_OFF_W = 12;
    localparam int PPN_W      = PA_W - PAGE_OFF_W;
    localparam int PTE_BYTES  = PTE_W / 8;
    localparam int ENTRY_SH   = $clog2(PTE_BYTES);

    // Entry layout: base on top, ignored bits, then write/read/valid
    typedef struct packed {
        logic [PPN_W-1:0]      base;
        logic [PAGE_OFF_W-4:0] spare;
        logic                  perm_w;
        logic                  perm_r;
        logic                  valid;
    } pte_t;

    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_L1_REQ  = 3'd1,
        WS_L1_WAIT = 3'd2,
        WS_L2_REQ  = 3'd3,
        WS_L2_WAIT = 3'd4,
        WS_RESP    = 3'd5
    } walk_state_e;

endpackage

// File: rtl/pt_root_reg.sv
// Module: holds the byte address of the first-level table.
// Assumes software writes it between walks or during one; the controller
// snapshots it when a request is accepted, so a mid-walk write only
// affects later walks.
module pt_root_reg #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] ROOT_RST = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] root
);

    // Load a new root on write, return to the reset value on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root <= ROOT_RST[ADDR_W-1:0];
        end else if (wr_en) begin
            root <= wr_data;
        end
    end

endmodule

// File: rtl/pt_entry_addr.sv
// Module: forms the byte address of the entry to fetch at the current level.
// Level 0 adds the scaled top index to the root; level 1 adds the scaled
// middle index to the page-aligned table base from the first entry.
// Purely combinational; assumes root and base are stable during a read.
module pt_entry_addr
    import pt_walk_pkg::*;
#(
    parameter int L1_IDX_W = 10,
    parameter int L2_IDX_W = 10,
    localparam int VA_W    = L1_IDX_W + L2_IDX_W + PAGE_OFF_W
) (
    input  logic [PA_W-1:0]  root,
    input  logic [PPN_W-1:0] tbl_base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             second_lvl,
    output logic [PA_W-1:0]  entry_addr
);

    localparam int NLVL = 2;

    logic [PA_W-1:0] idx_off [NLVL];
    logic [PA_W-1:0] lvl_base[NLVL];

    // One offset/base pair per level, each index field picked by position
    for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
        if (lv == 0) begin : g_top
            assign idx_off[lv]  = PA_W'(vaddr[VA_W-1 -: L1_IDX_W]) << ENTRY_SH;
            assign lvl_base[lv] = root;
        end else begin : g_mid
            assign idx_off[lv]  = PA_W'(vaddr[PAGE_OFF_W +: L2_IDX_W]) << ENTRY_SH;
            assign lvl_base[lv] = {tbl_base, {PAGE_OFF_W{1'b0}}};
        end
    end

    // Select the level being fetched and add its scaled index
    always_comb begin
        entry_addr = lvl_base[second_lvl] + idx_off[second_lvl];
    end

    logic unused_offset;
    assign unused_offset = ^vaddr[PAGE_OFF_W-1:0];

endmodule

// File: rtl/pt_walk_ctrl.sv
// Module: sequences a walk through both levels and builds the response.
// Assumes a memory port with at most one read in flight and a data beat
// arriving after the request is accepted. Accepts one request at a time;
// an invalid entry at either level ends the walk with a fault.
module pt_walk_ctrl
    import pt_walk_pkg::*;
#(
    parameter int L1_IDX_W = 10,
    parameter int L2_IDX_W = 10,
    localparam int VA_W    = L1_IDX_W + L2_IDX_W + PAGE_OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  root,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic             resp_fault_lvl,
    output logic [PPN_W-1:0] resp_ppn,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_perm_r,
    output logic             resp_perm_w,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic             rdata_valid,
    input  logic [PTE_W-1:0] rdata,
    output logic             second_lvl,
    output logic [PA_W-1:0]  root_snap,
    output logic [PPN_W-1:0] tbl_base,
    output logic [VA_W-1:0]  va_snap
);

    walk_state_e     state;
    pte_t            pte;
    logic [PPN_W-1:0] ppn_q;
    logic            perm_r_q;
    logic            perm_w_q;
    logic            fault_q;
    logic            fault_lvl_q;

    // View the returned word through the entry layout
    assign pte = pte_t'(rdata);

    // Walk sequencing, snapshots and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= WS_IDLE;
            va_snap     <= '0;
            root_snap   <= '0;
            tbl_base    <= '0;
            ppn_q       <= '0;
            perm_r_q    <= 1'b0;
            perm_w_q    <= 1'b0;
            fault_q     <= 1'b0;
            fault_lvl_q <= 1'b0;
        end else begin
            unique case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_snap     <= req_vaddr;
                        root_snap   <= root;
                        ppn_q       <= '0;
                        perm_r_q    <= 1'b0;
                        perm_w_q    <= 1'b0;
                        fault_q     <= 1'b0;
                        fault_lvl_q <= 1'b0;
                        state       <= WS_L1_REQ;
                    end
                end
                WS_L1_REQ: begin
                    if (rd_ready) state <= WS_L1_WAIT;
                end
                WS_L1_WAIT: begin
                    if (rdata_valid) begin
                        if (pte.valid) begin
                            tbl_base <= pte.base;
                            state    <= WS_L2_REQ;
                        end else begin
                            fault_q     <= 1'b1;
                            fault_lvl_q <= 1'b0;
                            state       <= WS_RESP;
                        end
                    end
                end
                WS_L2_REQ: begin
                    if (rd_ready) state <= WS_L2_WAIT;
                end
                WS_L2_WAIT: begin
                    if (rdata_valid) begin
                        if (pte.valid) begin
                            ppn_q    <= pte.base;
                            perm_r_q <= pte.perm_r;
                            perm_w_q <= pte.perm_w;
                        end else begin
                            fault_q     <= 1'b1;
                            fault_lvl_q <= 1'b1;
                        end
                        state <= WS_RESP;
                    end
                end
                WS_RESP: begin
                    state <= WS_IDLE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // Handshake and memory request strobes decoded from the state
    always_comb begin
        req_ready  = (state == WS_IDLE);
        resp_valid = (state == WS_RESP);
        rd_valid   = (state == WS_L1_REQ) || (state == WS_L2_REQ);
        second_lvl = (state == WS_L2_REQ) || (state == WS_L2_WAIT);
    end

    // Response fields; a faulted walk reports an all-zero translation
    always_comb begin
        resp_fault     = fault_q;
        resp_fault_lvl = fault_lvl_q;
        resp_ppn       = ppn_q;
        resp_perm_r    = perm_r_q;
        resp_perm_w    = perm_w_q;
        resp_paddr     = fault_q ? '0 : {ppn_q, va_snap[PAGE_OFF_W-1:0]};
    end

    logic unused_spare;
    assign unused_spare = ^pte.spare;

endmodule

// File: rtl/pt_walker.sv
// Module: top of the two-level page table walker.
// Ties the root register, the entry address former and the walk controller
// together. Assumes a byte-addressed read port returning one 32-bit entry
// per accepted read, with a single read outstanding.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int          L1_IDX_W = 10,
    parameter int          L2_IDX_W = 10,
    parameter logic [31:0] ROOT_RST = 32'h0,
    localparam int         VA_W     = L1_IDX_W + L2_IDX_W + PAGE_OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             root_wr_en,
    input  logic [PA_W-1:0]  root_wr_data,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic             resp_fault_lvl,
    output logic [PPN_W-1:0] resp_ppn,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_perm_r,
    output logic             resp_perm_w,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rdata_valid,
    input  logic [PTE_W-1:0] mem_rdata
);

    logic [PA_W-1:0]  root;
    logic [PA_W-1:0]  root_snap;
    logic [PPN_W-1:0] tbl_base;
    logic [VA_W-1:0]  va_snap;
    logic             second_lvl;

    pt_root_reg #(
        .ADDR_W  (PA_W),
        .ROOT_RST(ROOT_RST)
    ) u_root (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (root_wr_en),
        .wr_data(root_wr_data),
        .root   (root)
    );

    pt_entry_addr #(
        .L1_IDX_W(L1_IDX_W),
        .L2_IDX_W(L2_IDX_W)
    ) u_addr (
        .root      (root_snap),
        .tbl_base  (tbl_base),
        .vaddr     (va_snap),
        .second_lvl(second_lvl),
        .entry_addr(mem_rd_addr)
    );

    pt_walk_ctrl #(
        .L1_IDX_W(L1_IDX_W),
        .L2_IDX_W(L2_IDX_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .root          (root),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_fault_lvl(resp_fault_lvl),
        .resp_ppn      (resp_ppn),
        .resp_paddr    (resp_paddr),
        .resp_perm_r   (resp_perm_r),
        .resp_perm_w   (resp_perm_w),
        .rd_valid      (mem_rd_valid),
        .rd_ready      (mem_rd_ready),
        .rdata_valid   (mem_rdata_valid),
        .rdata         (mem_rdata),
        .second_lvl    (second_lvl),
        .root_snap     (root_snap),
        .tbl_base      (tbl_base),
        .va_snap       (va_snap)
    );

endmodule

// File: rtl/pt_walker_chk.sv
// Module: protocol checker for the walker's ports, attached by bind.
// Tracks reads in flight with a small counter; assumes the memory side
// returns data only for accepted reads.
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic        resp_perm_r,
    input logic        resp_perm_w,
    input logic [19:0] resp_ppn,
    input logic [31:0] resp_paddr,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rdata_valid
);

    logic [1:0] inflight;

    // Count accepted reads not yet answered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + {1'b0, mem_rd_valid && mem_rd_ready}
                                 - {1'b0, mem_rdata_valid};
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !resp_valid && !mem_rd_valid));

    assert_fault_zeroed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |->
            (resp_ppn == '0 && resp_paddr == '0 && !resp_perm_r && !resp_perm_w));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_ready_with_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    assert_ready_after_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_single_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |-> (inflight == 2'd0));

endmodule

bind pt_walker pt_walker_chk u_pt_walker_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .resp_fault     (resp_fault),
    .resp_perm_r    (resp_perm_r),
    .resp_perm_w    (resp_perm_w),
    .resp_ppn       (resp_ppn),
    .resp_paddr     (resp_paddr),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_ready   (mem_rd_ready),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rdata_valid(mem_rdata_valid)
);

// File: tb/test_pt_walker.sv
// Bench: sweeps both index levels against a hashed memory model and
// computes every expected address and response from the requirements.
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0;
    logic [31:0] root_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        resp_valid, resp_fault, resp_fault_lvl, resp_perm_r, resp_perm_w;
    logic [19:0] resp_ppn;
    logic [31:0] resp_paddr;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [31:0] mem_rd_addr;
    logic        mem_rdata_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit stall_en = 0;
    int cyc = 0;
    int rd_cnt = 0;
    logic [31:0] rd_log [4];
    bit pend = 0;
    logic [31:0] pend_addr = '0;

    always #2 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .root_wr_en(root_wr_en), .root_wr_data(root_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl),
        .resp_ppn(resp_ppn), .resp_paddr(resp_paddr),
        .resp_perm_r(resp_perm_r), .resp_perm_w(resp_perm_w),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata)
    );

    // Memory contents as a hash of the byte address; bits 11:3 are junk
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [19:0] b;
        b = (a[21:2] * 20'd40503) ^ a[31:12] ^ 20'h5A5A3;
        return {b, a[10:2] ^ 9'h1A5, a[4] ^ a[7], a[3] ^ a[8], a[2] ^ a[5] ^ a[9]};
    endfunction

    // Memory model: answer one cycle after an accepted read, optional stalls
    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_rdata_valid = 1'b0;
        if (pend) begin
            mem_rdata_valid = 1'b1;
            mem_rdata = mem_word(pend_addr);
            pend = 0;
        end
        mem_rd_ready = stall_en ? (cyc % 3 != 1) : 1'b1;
        if (mem_rd_valid && mem_rd_ready) begin
            pend = 1;
            pend_addr = mem_rd_addr;
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic write_root(input logic [31:0] v);
        root_wr_en = 1'b1;
        root_wr_data = v;
        @(negedge clk);
        root_wr_en = 1'b0;
    endtask

    // One walk: issue at a negedge, wait for the response, compare
    task automatic walk(input logic [31:0] root, input logic [31:0] va,
                        input bit poke, input bit root_chg, input logic [31:0] new_root);
        logic [31:0] a1, a2, e1, e2;
        bit ready_ok, got;
        int n;
        a1 = root + {20'd0, va[31:22], 2'b00};
        e1 = mem_word(a1);
        a2 = {e1[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
        e2 = mem_word(a2);
        rd_cnt = 0;
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ready_ok = 1;
        got = 0;
        n = 0;
        while (!got && n < 100) begin
            if (resp_valid) begin
                got = 1;
            end else begin
                if (req_ready) ready_ok = 0;
                n++;
                req_valid = poke && (n < 3);
                req_vaddr = ~va;
                if (root_chg && n == 1) begin
                    root_wr_en = 1'b1;
                    root_wr_data = new_root;
                end else begin
                    root_wr_en = 1'b0;
                end
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        root_wr_en = 1'b0;
        chk(got, "R8 response arrives", {63'd0, got}, 64'd1);
        chk(ready_ok, "R7 ready low during walk", {63'd0, ready_ok}, 64'd1);
        chk(rd_log[0] == a1, "R2 first read address", {32'd0, rd_log[0]}, {32'd0, a1});
        if (!e1[0]) begin
            chk(resp_fault && !resp_fault_lvl && resp_ppn == 0 && resp_paddr == 0
                && !resp_perm_r && !resp_perm_w && rd_cnt == 1,
                "R5 first-level fault",
                {rd_cnt[7:0], resp_fault, resp_fault_lvl, resp_perm_r, resp_perm_w,
                 resp_ppn, resp_paddr}, {8'd1, 4'b1000, 20'd0, 32'd0});
        end else begin
            chk(rd_log[1] == a2, "R3 second read address",
                {32'd0, rd_log[1]}, {32'd0, a2});
            if (!e2[0]) begin
                chk(resp_fault && resp_fault_lvl && resp_ppn == 0 && resp_paddr == 0
                    && !resp_perm_r && !resp_perm_w,
                    "R6 second-level fault",
                    {8'd0, resp_fault, resp_fault_lvl, resp_perm_r, resp_perm_w,
                     resp_ppn, resp_paddr}, {8'd0, 4'b1100, 20'd0, 32'd0});
            end else begin
                chk(!resp_fault && resp_ppn == e2[31:12]
                    && resp_paddr == {e2[31:12], va[11:0]}
                    && resp_perm_r == e2[1] && resp_perm_w == e2[2],
                    "R4 translation",
                    {8'd0, resp_fault, 1'b0, resp_perm_r, resp_perm_w, resp_ppn, resp_paddr},
                    {8'd0, 1'b0, 1'b0, e2[1], e2[2], e2[31:12], e2[31:12], va[11:0]});
                chk(rd_cnt == 2, "R10 two reads per translation",
                    64'(rd_cnt), 64'd2);
            end
        end
        @(negedge clk);
        chk(!resp_valid && req_ready, "R8 single-cycle response / R7 ready back",
            {62'd0, resp_valid, req_ready}, 64'd1);
        chk(rd_cnt <= 2, "R7 busy requests ignored", 64'(rd_cnt), 64'd2);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rootA, rootB;
        int good_l1;
        rootA = 32'h0040_0000;
        rootB = 32'h0123_4000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !resp_valid && !mem_rd_valid, "R1 reset outputs",
            {61'd0, req_ready, resp_valid, mem_rd_valid}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !mem_rd_valid, "R1 after reset",
            {61'd0, req_ready, resp_valid, mem_rd_valid}, 64'd4);
        // R1: root resets to zero, so the first walk reads from table at 0
        walk(32'h0, 32'h0040_1ABC, 0, 0, 0);
        walk(32'h0, 32'hFFC0_3123, 0, 0, 0);
        write_root(rootA);
        // First-level sweep (R2, R4, R5)
        for (int i = 0; i < 1024; i++) begin
            walk(rootA, {i[9:0], 10'(i * 7), 12'(i * 13)}, 0, 0, 0);
        end
        // Find a valid first-level entry for the second-level sweep
        good_l1 = 0;
        for (int i = 0; i < 1024; i++) begin
            if (good_l1 == 0 && mem_word(rootA + 32'(i * 4))[0]) good_l1 = i;
        end
        stall_en = 1;
        // Second-level sweep under back-pressure (R3, R4, R6, R10)
        for (int j = 0; j < 1024; j++) begin
            walk(rootA, {good_l1[9:0], j[9:0], 12'(j * 29 + 5)}, (j % 5) == 0, 0, 0);
        end
        // R9: a root write during a walk applies only afterwards
        walk(rootA, {good_l1[9:0], 10'd3, 12'h777}, 0, 1, rootB);
        walk(rootB, 32'h1234_5678, 0, 0, 0);
        walk(rootB, 32'h8765_4321, 1, 0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule